// File: doc/BRIEF.md
# Dual-Trigger Up Counter (Decade or Binary)

This block is a four-bit up counter that lives in a fast system clock domain. It watches two slow control lines, a count clock and a count enable, by oversampling them. Either line can act as the trigger. The count steps on a low-to-high change of the count clock while the enable is high. It also steps on a high-to-low change of the enable while the count clock is low.

An elaboration parameter selects decade counting (0 to 9) or plain binary counting (0 to 15). A high level on the clear input empties the counter at once and holds it at zero. All four output bits change together on the same system clock edge.

Because the enable line can act as the trigger, stages can be chained. Drive the enable of the next stage from the top bit of the previous one and tie its count clock low. The next stage then steps each time the previous stage wraps to zero.

Top module: `dual_edge_upcounter`

## Requirements
- R1: `q` is an unsigned binary number with `q[3]` as the most significant bit (weights 8, 4, 2, 1).
- R2: With MODULUS = 10 the count runs 0, 1, …, 9 and then returns to 0 on the next step.
- R3: With MODULUS = 16 the count runs 0, 1, …, 15 and then returns to 0 on the next step.
- R4: A low-to-high change of `clk_in` while `en_in` is high raises the count by one.
- R5: A high-to-low change of `en_in` while `clk_in` is low raises the count by one.
- R6: Nothing else changes the count. This covers a rise of `clk_in` with `en_in` low, a fall of `en_in` with `clk_in` high, a fall of `clk_in`, a rise of `en_in`, and steady inputs.
- R7: If a rise of `clk_in` and a fall of `en_in` are seen in the same synchronised sample, the count does not change.
- R8: While `clr_in` is high, `q` is zero. It goes to zero without waiting for a `clk` edge. After `clr_in` falls, `q` stays zero through two more rising edges of `clk`. Counting resumes from the third edge.
- R9: Each input passes through two synchroniser flops. A trigger edge present at rising `clk` edge n updates `q` at rising edge n+2.
- R10: Two blocks can be chained. The second block takes its `en_in` from the first block's `q[3]` and has `clk_in` tied low. The second block then steps once each time the first wraps from its top value to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the trigger lines |
| clr_in | input | 1 | Active-high clear; asserts asynchronously, released through a synchroniser |
| clk_in | input | 1 | Count clock line, asynchronous |
| en_in | input | 1 | Count enable line, asynchronous; also a trigger on its falling edge |
| q | output | 4 | Current count, bit 3 most significant |

## Verification
The assertions assume that `clr_in` is raised before the first `clk` edge. Without that, the synchroniser and count registers could start from unknown history. They also assume that `clk_in` and `en_in` are stable around each sampling edge, so each synchronised value is a clean copy of the pin. The stimulus meets these conditions. It raises the clear a fraction of a period after time zero. It changes every input one nanosecond after a falling `clk` edge and holds each level for at least one full system cycle. In the cascade, the second stage's enable is the first stage's registered output, so it is already clean.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  // Only decade and plain binary wrap points are supported.
  function automatic bit modulus_ok(input int m);
    return (m == 10) || (m == 16);
  endfunction

  // Register width needed to hold values 0 .. m-1.
  function automatic int count_width(input int m);
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/ucnt_sync.sv
module ucnt_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    pipe[0] <= d;
    for (int i = 1; i < STAGES; i++) begin
      pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/ucnt_clr_sync.sv
module ucnt_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_in,
  output logic clr_hold
);

  logic [STAGES-1:0] shreg;

  // Set at once by the clear; drained one stage per clock after release.
  always_ff @(posedge clk or posedge clr_in) begin
    if (clr_in) shreg <= '1;
    else        shreg <= {shreg[STAGES-2:0], 1'b0};
  end

  assign clr_hold = shreg[STAGES-1];

endmodule

// File: rtl/ucnt_trig.sv
module ucnt_trig (
  input  logic clk,
  input  logic clk_s,
  input  logic en_s,
  output logic step
);

  logic clk_p;
  logic en_p;
  logic clk_rise;
  logic en_fall;

  // The history follows the synchronised lines on every cycle. It is
  // therefore already reseeded when a clear is released.
  always_ff @(posedge clk) begin
    clk_p <= clk_s;
    en_p  <= en_s;
  end

  always_comb begin
    clk_rise = ~clk_p & clk_s;
    en_fall  = en_p & ~en_s;
    // Each path is gated by the settled level of the other line.
    // A rise and a fall together meet neither gate.
    step     = (clk_rise & en_s) | (en_fall & ~clk_s);
  end

endmodule

// File: rtl/ucnt_core.sv
module ucnt_core #(
  parameter int MODULUS = 10,
  parameter int W       = 4
) (
  input  logic         clk,
  input  logic         clr_in,
  input  logic         clr_hold,
  input  logic         step,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  logic [W-1:0] nxt;

  generate
    if (MODULUS == (1 << W)) begin : g_natural
      assign nxt = cnt + 1'b1;
    end else begin : g_decade
      assign nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  endgenerate

  // All bits load together, so there is no ripple inside the counter.
  always_ff @(posedge clk or posedge clr_in) begin
    if (clr_in)        cnt <= '0;
    else if (clr_hold) cnt <= '0;
    else if (step)     cnt <= nxt;
  end

endmodule

// File: rtl/dual_edge_upcounter.sv
module dual_edge_upcounter #(
  parameter int MODULUS     = 10,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_STAGES  = 2
) (
  input  logic       clk,
  input  logic       clr_in,
  input  logic       clk_in,
  input  logic       en_in,
  output logic [3:0] q
);

  import ucnt_pkg::*;

  localparam int W = count_width(MODULUS);

  generate
    if (!modulus_ok(MODULUS)) begin : g_bad_modulus
      $error("dual_edge_upcounter: MODULUS must be 10 or 16");
    end
  endgenerate

  logic [1:0]   lines_s;
  logic         clk_s;
  logic         en_s;
  logic         clr_hold;
  logic         step;
  logic [W-1:0] cnt;

  ucnt_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({clk_in, en_in}),
    .q   (lines_s)
  );

  assign clk_s = lines_s[1];
  assign en_s  = lines_s[0];

  ucnt_clr_sync #(.STAGES(CLR_STAGES)) u_clr (
    .clk      (clk),
    .clr_in   (clr_in),
    .clr_hold (clr_hold)
  );

  ucnt_trig u_trig (
    .clk   (clk),
    .clk_s (clk_s),
    .en_s  (en_s),
    .step  (step)
  );

  ucnt_core #(.MODULUS(MODULUS), .W(W)) u_core (
    .clk      (clk),
    .clr_in   (clr_in),
    .clr_hold (clr_hold),
    .step     (step),
    .cnt      (cnt)
  );

  assign q = 4'(cnt);

endmodule

// File: rtl/ucnt_checker.sv
module ucnt_checker #(
  parameter int MODULUS = 10
) (
  input logic       clk,
  input logic       clr_in,
  input logic       clr_hold,
  input logic       clk_s,
  input logic       en_s,
  input logic [3:0] q
);

  // R8: after a sampled clear, the count reads zero.
  a_r8_clear_zero: assert property (@(posedge clk)
    clr_in |=> (q == 4'd0));

  // R2 / R3: the count never leaves the chosen range.
  a_r2_r3_in_range: assert property (@(posedge clk) disable iff (clr_in)
    int'(q) < MODULUS);

  // R4: a clock rise with enable high adds one, with wrap.
  a_r4_clock_path: assert property (@(posedge clk) disable iff (clr_in)
    ($rose(clk_s) && en_s && !clr_hold)
      |=> (int'(q) == (int'($past(q)) + 1) % MODULUS));

  // R5: an enable fall with clock low adds one, with wrap.
  a_r5_enable_path: assert property (@(posedge clk) disable iff (clr_in)
    ($fell(en_s) && !clk_s && !clr_hold)
      |=> (int'(q) == (int'($past(q)) + 1) % MODULUS));

  // R7: a rise and a fall together give no step.
  a_r7_no_double: assert property (@(posedge clk) disable iff (clr_in)
    ($rose(clk_s) && $fell(en_s)) |=> $stable(q));

  // R6: without a qualifying edge the count holds.
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (clr_in)
    (!clr_hold && $stable(clk_s) && $stable(en_s)) |=> $stable(q));

  // R8: the count is held at zero while the released clear drains.
  a_r8_hold_zero: assert property (@(posedge clk) disable iff (clr_in)
    clr_hold |=> (q == 4'd0));

endmodule

bind dual_edge_upcounter ucnt_checker #(.MODULUS(MODULUS)) u_ucnt_checker (
  .clk      (clk),
  .clr_in   (clr_in),
  .clr_hold (clr_hold),
  .clk_s    (clk_s),
  .en_s     (en_s),
  .q        (q)
);

// File: tb/dual_edge_upcounter_bench.sv
module dual_edge_upcounter_bench;

  logic       clk = 1'b0;
  logic       clr_in = 1'b0;
  logic       clk_in = 1'b0;
  logic       en_in = 1'b0;
  logic [3:0] q_dec;
  logic [3:0] q_bin;
  logic [3:0] q_st2;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 1'b0;
  string tag = "R8";

  always #2 clk = ~clk;   // 250 MHz

  dual_edge_upcounter #(.MODULUS(10)) u_dual_edge_upcounter (
    .clk(clk), .clr_in(clr_in), .clk_in(clk_in), .en_in(en_in), .q(q_dec));

  dual_edge_upcounter #(.MODULUS(16)) u_bin (
    .clk(clk), .clr_in(clr_in), .clk_in(clk_in), .en_in(en_in), .q(q_bin));

  // R10: ripple stage driven from the decade stage's top bit.
  dual_edge_upcounter #(.MODULUS(10)) u_stage2 (
    .clk(clk), .clr_in(clr_in), .clk_in(1'b0), .en_in(q_dec[3]), .q(q_st2));

  // Reference model: histories of pin samples, integer counts.
  int hc[$] = '{0, 0, 0};
  int he[$] = '{0, 0, 0};
  int h2[$] = '{0, 0, 0};
  int ref_dec = 0;
  int ref_bin = 0;
  int ref_st2 = 0;
  int hold = 0;

  function automatic bit is_step(int pc, int pe, int nc, int ne);
    return ((pc == 0) && (nc == 1) && (ne == 1)) ||
           ((pe == 1) && (ne == 0) && (nc == 0));
  endfunction

  always @(posedge clk) begin
    bit ev;
    bit ev2;
    int st2_en;
    cycles++;
    // A pin value sampled at edge n reaches the count at edge n+2.
    ev  = is_step(hc[0], he[0], hc[1], he[1]);
    ev2 = is_step(0, h2[0], 0, h2[1]);
    st2_en = (ref_dec >= 8) ? 1 : 0;
    if (clr_in) begin
      ref_dec = 0; ref_bin = 0; ref_st2 = 0; hold = 2;
    end else if (hold > 0) begin
      ref_dec = 0; ref_bin = 0; ref_st2 = 0; hold--;
    end else begin
      if (ev) begin
        ref_dec = (ref_dec + 1) % 10;
        ref_bin = (ref_bin + 1) % 16;
      end
      if (ev2) ref_st2 = (ref_st2 + 1) % 10;
    end
    void'(hc.pop_front()); hc.push_back(int'(clk_in));
    void'(he.pop_front()); he.push_back(int'(en_in));
    void'(h2.pop_front()); h2.push_back(st2_en);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare on the falling edge, away from register updates.
  always @(negedge clk) begin
    if (started) begin
      chk({tag, " decade count"}, int'(q_dec), ref_dec);
      chk({tag, " binary count"}, int'(q_bin), ref_bin);
      chk("R10 cascade stage", int'(q_st2), ref_st2);
      chk("R1 msb weight", int'(q_bin[3]), (ref_bin >= 8) ? 1 : 0);
    end
  end

  task automatic drive(bit c, bit e, int n);
    @(negedge clk);
    #1;
    clk_in = c;
    en_in  = e;
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #1 clr_in = 1'b1;
    #1;
    chk("R8 reset state", int'(q_dec), 0);
    chk("R8 reset state", int'(q_bin), 0);
    repeat (3) @(posedge clk);
    started = 1'b1;
    @(negedge clk); #1 clr_in = 1'b0;
    repeat (4) @(posedge clk);

    // R9: one isolated step; the bench compares every cycle around it.
    tag = "R9";
    drive(1'b0, 1'b1, 1);
    drive(1'b1, 1'b1, 4);
    drive(1'b0, 1'b1, 2);

    // R4 with R2: clock pulses with enable high, past the decade wrap.
    tag = "R4 R2";
    for (int i = 0; i < 12; i++) begin
      drive(1'b1, 1'b1, 2);
      drive(1'b0, 1'b1, 2);
    end

    // R6: clock pulses with enable low do nothing.
    tag = "R6";
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b0, 2);
      drive(1'b1, 1'b0, 2);
    end
    // R6: enable falls while clock is high do nothing.
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b1, 2);
      drive(1'b1, 1'b0, 2);
    end

    // R5 with R3: enable falls with clock low, past the binary wrap.
    tag = "R5 R3";
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 1'b1, 2);
      drive(1'b0, 1'b0, 2);
    end

    // R7: a clock rise and an enable fall in the same sample.
    tag = "R7";
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b1, 3);
      drive(1'b1, 1'b0, 3);
    end

    // R8: clear in the middle of activity.
    tag = "R8";
    drive(1'b0, 1'b1, 2);
    drive(1'b1, 1'b1, 2);
    @(negedge clk); #1 clr_in = 1'b1;
    #1;
    chk("R8 async clear", int'(q_dec), 0);
    chk("R8 async clear", int'(q_bin), 0);
    drive(1'b0, 1'b1, 2);
    drive(1'b1, 1'b1, 2);
    @(negedge clk); #1 clr_in = 1'b0;
    drive(1'b0, 1'b1, 1);
    drive(1'b1, 1'b1, 2);
    drive(1'b0, 1'b1, 2);

    // R10: long mixed run so the cascade stage wraps as well.
    tag = "R10 R4 R5";
    for (int i = 0; i < 60; i++) begin
      drive(1'b1, 1'b1, 1);
      drive(1'b0, 1'b1, 2);
      drive(1'b0, 1'b0, 1);
    end
    drive(1'b0, 1'b1, 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule